// File: doc/BRIEF.md
# Bordered Colour-Bar Video Pattern Source

This block is a free-running video source for bringing up a pixel pipeline. It drives a ready/valid stream in which every frame is one packet. The first pixel of a frame carries a start marker and the last pixel carries an end marker. A pixel is handed over only in a cycle where the source offers it and the sink takes it. The source therefore never outruns the sink, and it holds its output still for as long as the sink stalls.

The picture is fixed when the block is built. It is either a flat field in one constant colour or eight equal-width vertical bars at three-quarter intensity. In both cases a black frame of parameterised thickness surrounds the picture. Frame width, frame height, border thickness, the pattern choice and the flat colour are all parameters. Frames follow each other with no gap, in raster order.

Top module: `cbar_pattern_src`

## Requirements
- R1: A pixel is consumed only on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop` and `out_eop` hold their values and `out_valid` stays high.
- R2: Consumed pixels follow raster order. Column x runs from 0 to W-1 within a line, and lines run from 0 to H-1.
- R3: `out_sop` is high exactly when the offered pixel is column 0 of line 0.
- R4: `out_eop` is high exactly when the offered pixel is column W-1 of line H-1. The pixel offered after an accepted end pixel is the start pixel of the next frame.
- R5: A pixel with x < B, x >= W-B, y < B or y >= H-B is black, `out_data` = 24'h000000.
- R6: In bar mode, an interior pixel belongs to bar k = ((x-B)*8)/(W-2B). Bars 0 to 7 are white, yellow, cyan, green, magenta, red, blue and black. `out_data` packs red in bits 23:16, green in bits 15:8 and blue in bits 7:0. A component that is present has the value 191 and an absent one has the value 0.
- R7: In flat mode, every interior pixel equals the FLAT_COLOR parameter.
- R8: While `rst_n` is low, `out_valid` is low. After release, the first pixel offered is pixel (0,0) with `out_sop` high.
- R9: A reset asserted partway through a frame discards that frame. After release, generation restarts at pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| out_ready | input | 1 | Sink can take a pixel this cycle |
| out_valid | output | 1 | A pixel is offered |
| out_data | output | 24 | Pixel value, R[23:16] G[15:8] B[7:0] |
| out_sop | output | 1 | Offered pixel is the first of a frame |
| out_eop | output | 1 | Offered pixel is the last of a frame |

## Verification
The assertions rely on two assumptions about the inputs. The sink may drive `out_ready` freely in every cycle. `rst_n` is the only other input, and its deassertion passes through the internal synchroniser, so every clocked check is gated by the synchronised reset rather than the raw pin. The stimulus runs two instances side by side, one in bar mode and one in flat mode, with small frame sizes. The sink is driven through a long stretch of continuous acceptance, then a long stall, then a pseudo-random accept pattern, and a reset is applied partway through a frame. The bench computes every pixel's expected colour and markers from its own raster position model.

// File: rtl/cbar_pkg.sv
package cbar_pkg;

  typedef logic [23:0] pix_t;

  typedef enum logic {
    PAT_FLAT = 1'b0,
    PAT_BARS = 1'b1
  } pat_e;

  localparam logic [7:0] LVL_75 = 8'd191;

  // Bar index bits select which components are absent:
  // bit1 clears red, bit2 clears green, bit0 clears blue.
  function automatic pix_t bar_rgb(input logic [2:0] idx);
    pix_t p;
    p[23:16] = idx[1] ? 8'd0 : LVL_75;
    p[15:8]  = idx[2] ? 8'd0 : LVL_75;
    p[7:0]   = idx[0] ? 8'd0 : LVL_75;
    return p;
  endfunction

endpackage

// File: rtl/cbar_rst_sync.sv
module cbar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cbar_raster_cnt.sv
module cbar_raster_cnt #(
  parameter int unsigned W  = 64,
  parameter int unsigned H  = 12,
  parameter int unsigned XW = $clog2(W),
  parameter int unsigned YW = $clog2(H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [XW-1:0] x,
  output logic [YW-1:0] y,
  output logic          first,
  output logic          last
);

  localparam logic [XW-1:0] X_END = XW'(W - 1);
  localparam logic [YW-1:0] Y_END = YW'(H - 1);

  logic [XW-1:0] x_q, x_d;
  logic [YW-1:0] y_q, y_d;

  always_comb begin
    x_d = x_q;
    y_d = y_q;
    if (x_q == X_END) begin
      x_d = '0;
      y_d = (y_q == Y_END) ? '0 : y_q + 1'b1;
    end else begin
      x_d = x_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (adv) begin
      x_q <= x_d;
      y_q <= y_d;
    end
  end

  assign x     = x_q;
  assign y     = y_q;
  assign first = (x_q == '0) && (y_q == '0);
  assign last  = (x_q == X_END) && (y_q == Y_END);

  AST_X_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(x_q) < W); // R2
  AST_Y_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(y_q) < H); // R2
  AST_HOLD_NO_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(x_q) && $stable(y_q)); // R1

endmodule

// File: rtl/cbar_color_map.sv
module cbar_color_map
  import cbar_pkg::*;
#(
  parameter int unsigned W          = 64,
  parameter int unsigned H          = 12,
  parameter int unsigned B          = 2,
  parameter pat_e        PATTERN    = PAT_BARS,
  parameter pix_t        FLAT_COLOR = 24'h4080C0,
  parameter int unsigned XW         = $clog2(W),
  parameter int unsigned YW         = $clog2(H)
) (
  input  logic [XW-1:0] x,
  input  logic [YW-1:0] y,
  output pix_t          pix
);

  localparam int unsigned INNER_W = W - 2 * B;

  logic [31:0] xe;
  logic [31:0] ye;
  logic        border;
  pix_t        inner;

  assign xe = 32'(x);
  assign ye = 32'(y);

  assign border = (xe < B) || (xe >= W - B) || (ye < B) || (ye >= H - B);

  generate
    if (PATTERN == PAT_BARS) begin : g_bars
      logic [2:0] idx;
      assign idx   = 3'(((xe - B) * 8) / INNER_W);
      assign inner = bar_rgb(idx);
    end else begin : g_flat
      assign inner = FLAT_COLOR;
    end
  endgenerate

  assign pix = border ? '0 : inner;

endmodule

// File: rtl/cbar_pattern_src.sv
module cbar_pattern_src
  import cbar_pkg::*;
#(
  parameter int unsigned W          = 64,
  parameter int unsigned H          = 12,
  parameter int unsigned B          = 2,
  parameter pat_e        PATTERN    = PAT_BARS,
  parameter pix_t        FLAT_COLOR = 24'h4080C0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [23:0] out_data,
  output logic        out_sop,
  output logic        out_eop
);

  localparam int unsigned XW = (W > 1) ? $clog2(W) : 1;
  localparam int unsigned YW = (H > 1) ? $clog2(H) : 1;

  logic          rst_sync_n;
  logic          valid_q, valid_d;
  logic          adv;
  logic [XW-1:0] px;
  logic [YW-1:0] py;
  logic          first, last;
  pix_t          pix;

  cbar_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign valid_d = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign adv = valid_q & out_ready;

  cbar_raster_cnt #(.W(W), .H(H), .XW(XW), .YW(YW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (adv),
    .x     (px),
    .y     (py),
    .first (first),
    .last  (last)
  );

  cbar_color_map #(
    .W(W), .H(H), .B(B), .PATTERN(PATTERN), .FLAT_COLOR(FLAT_COLOR),
    .XW(XW), .YW(YW)
  ) u_map (
    .x   (px),
    .y   (py),
    .pix (pix)
  );

  assign out_valid = valid_q;
  assign out_data  = pix;
  assign out_sop   = valid_q & first;
  assign out_eop   = valid_q & last;

  logic on_edge;
  assign on_edge = (32'(px) < B) || (32'(px) >= W - B) ||
                   (32'(py) < B) || (32'(py) >= H - B);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) &&
    $stable(out_sop) && $stable(out_eop)); // R1
  AST_EOP_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ready && out_eop) |=> out_sop); // R4
  AST_SOP_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(out_valid) |-> out_sop); // R8
  AST_BORDER_BLACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && on_edge) |-> out_data == 24'h000000); // R5
  AST_MARKERS_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (W * H > 1) |-> !(out_sop && out_eop)); // R3

endmodule

// File: tb/tb_cbar_pattern_src.sv
`timescale 1ns/1ps
module tb_cbar_pattern_src;
  import cbar_pkg::*;

  localparam int unsigned W0 = 20, H0 = 6, B0 = 1;
  localparam int unsigned W1 = 12, H1 = 5, B1 = 2;
  localparam logic [23:0] FLAT = 24'h123456;
  localparam int NCYC = 1600;

  logic clk = 1'b0;
  logic rst_n;
  logic rdy;
  logic v0, s0, e0, v1, s1, e1;
  logic [23:0] d0, d1;

  always #2.5 clk = ~clk;

  cbar_pattern_src #(.W(W0), .H(H0), .B(B0), .PATTERN(PAT_BARS)) dut (
    .clk(clk), .rst_n(rst_n), .out_ready(rdy),
    .out_valid(v0), .out_data(d0), .out_sop(s0), .out_eop(e0));

  cbar_pattern_src #(.W(W1), .H(H1), .B(B1), .PATTERN(PAT_FLAT),
                     .FLAT_COLOR(FLAT)) dut_flat (
    .clk(clk), .rst_n(rst_n), .out_ready(rdy),
    .out_valid(v1), .out_data(d1), .out_sop(s1), .out_eop(e1));

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] bar_color(input int k);
    case (k)
      0: return 24'hBFBFBF;
      1: return 24'hBFBF00;
      2: return 24'h00BFBF;
      3: return 24'h00BF00;
      4: return 24'hBF00BF;
      5: return 24'hBF0000;
      6: return 24'h0000BF;
      default: return 24'h000000;
    endcase
  endfunction

  function automatic bit is_edge(input int w, input int h, input int b, input int x, input int y);
    return (x < b) || (x >= w - b) || (y < b) || (y >= h - b);
  endfunction

  int ex[2], ey[2];
  bit acc[2], pstall[2], pvalid[2];
  logic [23:0] pd[2];
  logic [15:0] lfsr = 16'hACE1;

  initial begin
    rst_n = 1'b0;
    rdy   = 1'b0;
    for (int k = 0; k < 2; k++) begin
      ex[k] = 0; ey[k] = 0; acc[k] = 0; pstall[k] = 0; pvalid[k] = 0; pd[k] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R8 valid low in reset", {23'd0, v0}, 24'd0);
    chk("R8 valid low in reset", {23'd0, v1}, 24'd0);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        int w, h, b;
        logic vv, ss, ee;
        logic [23:0] dd, exp_d;
        string tag;
        w  = (k == 0) ? W0 : W1;
        h  = (k == 0) ? H0 : H1;
        b  = (k == 0) ? B0 : B1;
        vv = (k == 0) ? v0 : v1;
        ss = (k == 0) ? s0 : s1;
        ee = (k == 0) ? e0 : e1;
        dd = (k == 0) ? d0 : d1;
        if (acc[k]) begin
          if (ex[k] == w - 1) begin
            ex[k] = 0;
            ey[k] = (ey[k] == h - 1) ? 0 : ey[k] + 1;
          end else begin
            ex[k] = ex[k] + 1;
          end
        end
        if (!rst_n) begin
          chk("R8 valid low in reset", {23'd0, vv}, 24'd0);
        end else if (vv) begin
          if (is_edge(w, h, b, ex[k], ey[k])) begin
            exp_d = 24'h000000; tag = "R5 border";
          end else if (k == 0) begin
            exp_d = bar_color(((ex[k] - b) * 8) / (w - 2 * b)); tag = "R6 bar colour";
          end else begin
            exp_d = FLAT; tag = "R7 flat colour";
          end
          chk(tag, dd, exp_d);
          chk("R2 R3 sop", {23'd0, ss}, {23'd0, (ex[k] == 0 && ey[k] == 0)});
          chk("R4 eop", {23'd0, ee}, {23'd0, (ex[k] == w - 1 && ey[k] == h - 1)});
          if (pstall[k]) chk("R1 stall hold", dd, pd[k]);
          if (!pvalid[k]) chk("R8 R9 restart sop", {23'd0, ss}, 24'd1);
        end
        pvalid[k] = vv;
        pd[k]     = dd;
      end
      if (c == 700) begin
        rst_n = 1'b0;
        for (int k = 0; k < 2; k++) begin
          ex[k] = 0; ey[k] = 0;
        end
      end else if (c == 706) begin
        rst_n = 1'b1;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (c < 300)      rdy = 1'b1;
      else if (c < 360) rdy = 1'b0;
      else              rdy = (lfsr[1:0] != 2'b00);
      acc[0] = v0 && rdy && rst_n;
      acc[1] = v1 && rdy && rst_n;
      pstall[0] = v0 && !rdy && rst_n;
      pstall[1] = v1 && !rdy && rst_n;
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end

endmodule